// File: doc/BRIEF.md
# Serial Line Encoder for a 10-bit Video Word Stream

This block turns a stream of 10-bit words into a single serial line, one bit per clock. It loads a new word every ten clocks and emits its bits starting from the least significant one. Each bit passes through a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1, and the result is then differentially encoded (x + 1): a scrambled one flips the line level and a scrambled zero keeps it. The scrambler keeps the DC content of the line low. The differential step makes the line insensitive to polarity.

A bypass control sends the raw bits straight to the line with the same latency. This is used for data that is already scrambled or that uses another line code. A clear control zeroes the scrambler history and the line-level register. A lock input mutes the line: while lock is low, the output flop holds its last level and the encoders keep running behind it.

The upstream source presents a word on `word_i` and moves to the next word after the block signals, on `take_o`, that the word is being captured.

Top module: `sdi_serial_tx`

## Requirements
- R1: While `rst_ni` is low, `ser_o` and `take_o` are 0. After `rst_ni` rises, `take_o` first goes high in the cycle after the 11th rising edge: 2 edges of reset synchronization plus 9 counts.
- R2: `take_o` is high for exactly one cycle in every 10. `word_i` is captured at the rising edge that ends a `take_o` cycle.
- R3: Bits leave least significant first. Bit k of a word (k = 0..9) reaches `ser_o` after the (k+3)-th rising edge counted from the capture edge, where the capture edge is edge 1. Bypass and encoded modes have the same latency.
- R4: With `bypass_i` low, each bit d is scrambled as c = d XOR c(-4) XOR c(-9). Here c(-j) is the scrambled bit produced j bits earlier, and the history is all zero after a clear.
- R5: With `bypass_i` low, the line level toggles for every scrambled 1 and holds for every scrambled 0. The level register starts at 0 after a clear.
- R6: With `bypass_i` high, `ser_o` carries the unscrambled, unencoded bits, with the latency of R3.
- R7: While `enc_clear_i` is high, the scrambler history and the line level are held at zero. With bypass low and lock high, `ser_o` is therefore 0 from the second edge after clear rises.
- R8: At a rising edge where `lock_i` is low, `ser_o` keeps its previous value.
- R9: Muting does not stall encoding. When `lock_i` returns high, `ser_o` shows the same level the unmuted sequence would have reached at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_i | input | 10 | Parallel word to transmit |
| take_o | output | 1 | High in the cycle whose closing edge captures `word_i` |
| bypass_i | input | 1 | 1: send raw bits; 0: scramble and differentially encode |
| enc_clear_i | input | 1 | 1: zero the scrambler history and line level |
| lock_i | input | 1 | 0: mute, hold `ser_o` at its last level |
| ser_o | output | 1 | Serial line output |

## Verification
The encoded path is driven with all-zero words, all-one words, an alternating 0x2AA word, sync-like extremes (0x000, 0x3FF, 0x001), and seeded random words.
- All zeros from a cleared state must give a flat line, which separates a correctly zeroed history from a stale one.
- All ones exercise both feedback taps, and a wrong tap position or a wrong encoder shows up within a few bits.
- The alternating and extreme words expose bit order and word-boundary slips.

Bypass runs with random words tell a latency or ordering fault apart from a scrambling fault. Random mute stretches over random data check both that the output holds and that the encoders keep running underneath.

// File: rtl/sdi_tx_pkg.sv
package sdi_tx_pkg;
  localparam int unsigned WORD_W  = 10;
  localparam int unsigned SCR_LEN = 9;
  localparam int unsigned SCR_TAP = 4;
  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  output logic              bit_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              load;

  assign load = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = load ? '0 : cnt_q + CNT_W'(1);
    sreg_d = load ? word_i : {1'b0, sreg_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end

  assign take_o = load;
  assign bit_o  = sreg_q[0];
endmodule

// File: rtl/sdi_lfsr_scrambler.sv
module sdi_lfsr_scrambler #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [LEN-1:0] hist_q, hist_d;
  logic           scr;

  // feedback from the scrambled bits TAP and LEN positions back
  assign scr = bit_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];

  always_comb begin
    hist_d = hist_q;
    if (clr_i)     hist_d = '0;
    else if (en_i) hist_d = {hist_q[LEN-2:0], scr};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign bit_o = scr;
endmodule

// File: rtl/sdi_nrzi_enc.sv
module sdi_nrzi_enc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic lvl_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (clr_i)     lvl_d = 1'b0;
    else if (en_i) lvl_d = lvl_q ^ bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/sdi_serial_tx.sv
module sdi_serial_tx
  import sdi_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = sdi_tx_pkg::WORD_W,
  parameter int unsigned SCR_LEN = sdi_tx_pkg::SCR_LEN,
  parameter int unsigned SCR_TAP = sdi_tx_pkg::SCR_TAP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  input  logic              bypass_i,
  input  logic              enc_clear_i,
  input  logic              lock_i,
  output logic              ser_o
);
  localparam int unsigned SYNC_N = RST_SYNC_STAGES;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_q;
  logic              nrz_bit;
  logic              scr_bit;
  logic              lvl;
  logic              enc_en;
  logic              raw_q;
  logic              ser_q, ser_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[SYNC_N-1];

  sdi_word_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .word_i (word_i),
    .take_o (take_o),
    .bit_o  (nrz_bit)
  );

  assign enc_en = !bypass_i;

  sdi_lfsr_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) scrambler_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .clr_i  (enc_clear_i),
    .en_i   (enc_en),
    .bit_i  (nrz_bit),
    .bit_o  (scr_bit)
  );

  sdi_nrzi_enc nrzi_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .clr_i  (enc_clear_i),
    .en_i   (enc_en),
    .bit_i  (scr_bit),
    .lvl_o  (lvl)
  );

  // raw path delay matches the encoder register stage
  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) raw_q <= 1'b0;
    else          raw_q <= nrz_bit;
  end

  always_comb begin
    ser_d = ser_q;
    if (lock_i) ser_d = bypass_i ? raw_q : lvl;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) ser_q <= 1'b0;
    else          ser_q <= ser_d;
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/sdi_serial_tx_chk.sv
module sdi_serial_tx_chk #(
  parameter int unsigned WORD_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic take_o,
  input logic bypass_i,
  input logic enc_clear_i,
  input logic lock_i,
  input logic ser_o,
  input logic nrz_bit
);
  localparam int unsigned GAP_W = $clog2(WORD_W) + 1;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (take_o) gap_q <= '0;
    else             gap_q <= gap_q + GAP_W'(1);
  end

  assert_take_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (gap_q == GAP_W'(WORD_W - 1)));

  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GAP_W'(WORD_W));

  assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  assert_mute_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> $stable(ser_o));

  assert_bypass_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && lock_i) |=> (ser_o == $past(nrz_bit, 2)));

  assert_clear_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enc_clear_i) && !bypass_i && lock_i) |=> !ser_o);
endmodule

bind sdi_serial_tx sdi_serial_tx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk_i),
  .rst_n       (rst_n_q),
  .take_o      (take_o),
  .bypass_i    (bypass_i),
  .enc_clear_i (enc_clear_i),
  .lock_i      (lock_i),
  .ser_o       (ser_o),
  .nrz_bit     (nrz_bit)
);

// File: tb/sdi_serial_tx_tb.sv
module sdi_serial_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [9:0] word_i;
  logic       take_o;
  logic       bypass_i;
  logic       enc_clear_i;
  logic       lock_i;
  logic       ser_o;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  logic [9:0] wq [0:31];
  logic       exp_s [0:319];

  always #5 clk_i = ~clk_i;

  sdi_serial_tx dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_i),
    .take_o      (take_o),
    .bypass_i    (bypass_i),
    .enc_clear_i (enc_clear_i),
    .lock_i      (lock_i),
    .ser_o       (ser_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // Reference stream: raw bits (bypass) or x^9+x^4+1 scrambling then x+1 encoding
  task automatic build_stream(input int nw, input bit byp);
    logic [8:0] s = '0;
    logic       lv = 1'b0;
    for (int k = 0; k < nw * 10; k++) begin
      logic d, c;
      d = wq[k / 10][k % 10];
      if (byp) exp_s[k] = d;
      else begin
        c = d ^ s[3] ^ s[8];
        s = {s[7:0], c};
        lv = lv ^ c;
        exp_s[k] = lv;
      end
    end
  endtask

  task automatic run_phase(input int nw, input bit byp, input bit mute_on, input string tag);
    int  wi;
    bit  lk;
    logic prev;
    build_stream(nw, byp);
    bypass_i    = byp;
    lock_i      = 1'b1;
    enc_clear_i = 1'b1;
    repeat (12) @(negedge clk_i);
    while (!take_o) @(negedge clk_i);
    word_i = wq[0];
    @(negedge clk_i);
    enc_clear_i = 1'b0;
    wi   = 1;
    lk   = 1'b1;
    prev = 1'b0;
    for (int n = 1; n <= nw * 10 + 2; n++) begin
      if (n > 1) @(negedge clk_i);
      // R2: load strobe every 10th cycle
      chk(take_o == ((n % 10) == 0), {tag, " R2 take"}, int'(take_o), int'((n % 10) == 0));
      if (n >= 3) begin
        logic e;
        e = lk ? exp_s[n - 3] : prev;
        prev = e;
        // R3/R4/R5/R6/R8/R9 depending on phase
        chk(ser_o == e, tag, int'(ser_o), int'(e));
      end
      if (take_o && wi < nw) begin
        word_i = wq[wi];
        wi++;
      end
      if (mute_on && n >= 2) begin
        if (lk) lk = ($urandom % 8) != 0;
        else    lk = ($urandom % 3) == 0;
      end else lk = 1'b1;
      lock_i = lk;
    end
    lock_i = 1'b1;
  endtask

  initial begin
    int m;
    void'($urandom(32'd7321));
    rst_ni      = 1'b0;
    word_i      = '0;
    bypass_i    = 1'b0;
    enc_clear_i = 1'b0;
    lock_i      = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(ser_o == 1'b0, "R1 ser in reset", int'(ser_o), 0);
    chk(take_o == 1'b0, "R1 take in reset", int'(take_o), 0);
    rst_ni = 1'b1;
    m = 0;
    while (!take_o && m < 40) begin
      @(negedge clk_i);
      m++;
      if (!take_o) chk(ser_o == 1'b0, "R1 ser idle", int'(ser_o), 0);
    end
    chk(m == 11, "R1 first take", m, 11);

    // Encoded path: directed patterns then random (R3 R4 R5)
    wq[0] = 10'h000; wq[1] = 10'h000; wq[2] = 10'h3FF; wq[3] = 10'h3FF;
    wq[4] = 10'h2AA; wq[5] = 10'h001; wq[6] = 10'h3FC;
    for (int i = 7; i < 18; i++) wq[i] = 10'($urandom);
    run_phase(18, 1'b0, 1'b0, "R3 R4 R5 encoded");

    // Flat line from all-zero words after clear (R4 R5)
    for (int i = 0; i < 3; i++) wq[i] = 10'h000;
    run_phase(3, 1'b0, 1'b0, "R4 R5 zeros");

    // Bypass path (R6 R3)
    wq[0] = 10'h001; wq[1] = 10'h200; wq[2] = 10'h2AA;
    for (int i = 3; i < 12; i++) wq[i] = 10'($urandom);
    run_phase(12, 1'b1, 1'b0, "R6 R3 bypass");

    // Random mute stretches, encoded then bypass (R8 R9)
    for (int i = 0; i < 24; i++) wq[i] = 10'($urandom);
    run_phase(24, 1'b0, 1'b1, "R8 R9 mute enc");
    for (int i = 0; i < 10; i++) wq[i] = 10'($urandom);
    run_phase(10, 1'b1, 1'b1, "R8 mute byp");

    // Clear held with all-one words (R7)
    bypass_i    = 1'b0;
    lock_i      = 1'b1;
    word_i      = 10'h3FF;
    repeat (12) @(negedge clk_i);
    enc_clear_i = 1'b1;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 20; i++) begin
      chk(ser_o == 1'b0, "R7 clear holds low", int'(ser_o), 0);
      @(negedge clk_i);
    end
    enc_clear_i = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule